// File: doc/BRIEF.md
# 64-bit Integer Shift Unit with 32-bit Word Forms

This block performs the shift operations of a 64-bit integer datapath: logical left, logical right and arithmetic right. Each operation comes in a full-width form and a 32-bit word form. The shift amount comes either from a 64-bit shift-source register value or from a 6-bit immediate. The caller presents an operand, both amount sources, an operation code, an immediate/register select and a word-mode flag. One clock later the unit returns a 64-bit result and a flag that marks an illegal encoding.

In word mode the unit works only on the low 32 bits of the operand. The amount is limited to five bits, and the 32-bit result is sign-extended to 64 bits. An immediate word shift whose amount field has bit 5 set is a reserved encoding, and so is operation code 3. Either case raises the illegal flag and forces the result to zero. Internally there is one right-shifting logarithmic shifter. Left shifts run through it by reversing the bit order on the way in and on the way out.

Top module: `rv64_shift_unit`

## Requirements
- R1: Operation code 0 (logical left) in full-width mode returns the operand shifted left by the amount, with zeros entering at bit 0.
- R2: Operation code 1 (logical right) in full-width mode returns the operand shifted right, with zeros entering at bit 63.
- R3: Operation code 2 (arithmetic right) in full-width mode returns the operand shifted right, with copies of operand bit 63 entering at the top.
- R4: A full-width register-sourced shift uses only bits 5:0 of the shift source. An amount of zero passes the operand through unchanged.
- R5: In word mode (word_mode=1), operand bits 63:32 have no effect on the result, and result bits 63:31 are all equal to bit 31 of the 32-bit result.
- R6: A word-mode register-sourced shift uses only bits 4:0 of the shift source.
- R7: A word-mode arithmetic right shift fills from bit 31 downward with operand bit 31.
- R8: A word-mode logical right shift zero-fills the 32-bit value. With amount 0 the result is negative when operand bit 31 is set. With any nonzero amount the result is non-negative.
- R9: With use_imm=1 and word_mode=1, an immediate with bit 5 set asserts illegal and gives result 0. The same bit in a register shift source is not illegal.
- R10: Operation code 3 asserts illegal and gives result 0, whatever the mode.
- R11: While rst is high, the result and illegal registers go to 0. Otherwise both outputs reflect the inputs sampled at the previous rising clock edge.
- R12: With use_imm=1 in full-width mode, the amount is imm_amt[5:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opd_a | input | 64 | Operand to shift |
| rs_src | input | 64 | Register shift-amount source |
| imm_amt | input | 6 | Immediate shift amount |
| use_imm | input | 1 | 1 selects imm_amt, 0 selects rs_src |
| op_sel | input | 2 | 0 left logical, 1 right logical, 2 right arithmetic, 3 reserved |
| word_mode | input | 1 | 1 selects the 32-bit word form |
| result | output | 64 | Registered shift result |
| illegal | output | 1 | Registered illegal-encoding flag |

## Verification
Both result and illegal are due exactly one rising edge after the inputs that produce them: one edge through the output register, with no further stage. The bench changes inputs on a falling edge and reads the outputs on the next falling edge. Every check therefore sees the outputs registered at the single rising edge between those two falling edges. The assertions that use implication to the next cycle follow the same one-cycle spacing.

// File: rtl/shf_pkg.sv
package shf_pkg;
  typedef enum logic [1:0] {
    SH_LL  = 2'b00,
    SH_RL  = 2'b01,
    SH_RA  = 2'b10,
    SH_RSV = 2'b11
  } sh_op_e;
endpackage

// File: rtl/shf_ctrl.sv
// Amount selection, encoding legality and operand preparation.
module shf_ctrl #(
  parameter int XLEN = 64,
  parameter int WLEN = 32,
  parameter int AMTW = $clog2(XLEN)
) (
  input  logic [XLEN-1:0] opd,
  input  logic [XLEN-1:0] rs_src,
  input  logic [AMTW-1:0] imm,
  input  logic            use_imm,
  input  logic [1:0]      op,
  input  logic            word_mode,
  output logic [AMTW-1:0] amt,
  output logic            bad_enc,
  output logic [XLEN-1:0] prep,
  output logic            rev,
  output logic            fill
);
  import shf_pkg::*;
  localparam int WAMTW = $clog2(WLEN);

  sh_op_e          op_e;
  logic [AMTW-1:0] raw_amt;
  logic            upper_fill;

  always_comb begin
    op_e    = sh_op_e'(op);
    raw_amt = use_imm ? imm : rs_src[AMTW-1:0];
    amt     = raw_amt;
    if (word_mode) amt[AMTW-1:WAMTW] = '0;
    bad_enc = (op_e == SH_RSV) | (word_mode & use_imm & (|imm[AMTW-1:WAMTW]));
    // word form: only the low half matters; upper half becomes the fill
    upper_fill = (op_e == SH_RA) & opd[WLEN-1];
    if (word_mode) prep = {{(XLEN-WLEN){upper_fill}}, opd[WLEN-1:0]};
    else           prep = opd;
    rev  = (op_e == SH_LL);
    fill = (op_e == SH_RA) & prep[XLEN-1];
  end
endmodule

// File: rtl/shf_barrel.sv
// Logarithmic right shifter; bit reversal around it yields left shifts.
module shf_barrel #(
  parameter int XLEN = 64,
  parameter int AMTW = $clog2(XLEN)
) (
  input  logic [XLEN-1:0] din,
  input  logic [AMTW-1:0] amt,
  input  logic            rev,
  input  logic            fill,
  output logic [XLEN-1:0] dout
);
  logic [XLEN-1:0] stg [0:AMTW];

  for (genvar i = 0; i < XLEN; i++) begin : g_in
    assign stg[0][i] = rev ? din[XLEN-1-i] : din[i];
  end

  for (genvar s = 0; s < AMTW; s++) begin : g_stage
    localparam int SH = 1 << s;
    assign stg[s+1] = amt[s] ? {{SH{fill}}, stg[s][XLEN-1:SH]} : stg[s];
  end

  for (genvar i = 0; i < XLEN; i++) begin : g_out
    assign dout[i] = rev ? stg[AMTW][XLEN-1-i] : stg[AMTW][i];
  end
endmodule

// File: rtl/shf_wfin.sv
// Word-form sign extension and zeroing of illegal encodings.
module shf_wfin #(
  parameter int XLEN = 64,
  parameter int WLEN = 32
) (
  input  logic [XLEN-1:0] sh,
  input  logic            word_mode,
  input  logic            bad_enc,
  output logic [XLEN-1:0] res
);
  always_comb begin
    if (bad_enc)        res = '0;
    else if (word_mode) res = {{(XLEN-WLEN){sh[WLEN-1]}}, sh[WLEN-1:0]};
    else                res = sh;
  end
endmodule

// File: rtl/rv64_shift_unit.sv
module rv64_shift_unit #(
  parameter int XLEN = 64,
  parameter int WLEN = 32,
  parameter int AMTW = $clog2(XLEN)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [XLEN-1:0] opd_a,
  input  logic [XLEN-1:0] rs_src,
  input  logic [AMTW-1:0] imm_amt,
  input  logic            use_imm,
  input  logic [1:0]      op_sel,
  input  logic            word_mode,
  output logic [XLEN-1:0] result,
  output logic            illegal
);
  localparam int WAMTW = $clog2(WLEN);

  logic [AMTW-1:0] amt_c;
  logic            bad_c, rev_c, fill_c;
  logic [XLEN-1:0] prep_c, sh_c, res_c;

  shf_ctrl #(.XLEN(XLEN), .WLEN(WLEN), .AMTW(AMTW)) u_ctrl (
    .opd(opd_a), .rs_src(rs_src), .imm(imm_amt), .use_imm(use_imm),
    .op(op_sel), .word_mode(word_mode), .amt(amt_c), .bad_enc(bad_c),
    .prep(prep_c), .rev(rev_c), .fill(fill_c)
  );

  shf_barrel #(.XLEN(XLEN), .AMTW(AMTW)) u_barrel (
    .din(prep_c), .amt(amt_c), .rev(rev_c), .fill(fill_c), .dout(sh_c)
  );

  shf_wfin #(.XLEN(XLEN), .WLEN(WLEN)) u_wfin (
    .sh(sh_c), .word_mode(word_mode), .bad_enc(bad_c), .res(res_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result  <= '0;
      illegal <= 1'b0;
    end else begin
      result  <= res_c;
      illegal <= bad_c;
    end
  end

  p_word_amt_r6: assert property (@(posedge clk) disable iff (rst)
    word_mode |-> (amt_c < AMTW'(WLEN)));

  p_illegal_zero_r9: assert property (@(posedge clk) disable iff (rst)
    illegal |-> (result == '0));

  p_imm_word_rsv_r9: assert property (@(posedge clk) disable iff (rst)
    (word_mode && use_imm && (|imm_amt[AMTW-1:WAMTW])) |=> illegal);

  p_reserved_op_r10: assert property (@(posedge clk) disable iff (rst)
    (op_sel == 2'b11) |=> (illegal && result == '0));

  p_word_sext_r5: assert property (@(posedge clk) disable iff (rst)
    word_mode |=> (result[XLEN-1:WLEN-1] == '0 || result[XLEN-1:WLEN-1] == '1));

  p_zero_pass_r4: assert property (@(posedge clk) disable iff (rst)
    (!word_mode && op_sel != 2'b11 && !use_imm && rs_src[AMTW-1:0] == '0)
    |=> (result == $past(opd_a)));

  p_srl_word_pos_r8: assert property (@(posedge clk) disable iff (rst)
    (word_mode && op_sel == 2'b01 && !use_imm && rs_src[WAMTW-1:0] != '0)
    |=> !result[XLEN-1]);

  p_sra_sign_r3: assert property (@(posedge clk) disable iff (rst)
    (!word_mode && op_sel == 2'b10) |=> (result[XLEN-1] == $past(opd_a[XLEN-1])));

  p_sll_lsb_r1: assert property (@(posedge clk) disable iff (rst)
    (!word_mode && op_sel == 2'b00 && !use_imm && rs_src[0]) |=> !result[0]);
endmodule

// File: tb/rv64_shift_unit_bench.sv
module rv64_shift_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] opd_a = '0, rs_src = '0;
  logic [5:0]  imm_amt = '0;
  logic        use_imm = 1'b0, word_mode = 1'b0;
  logic [1:0]  op_sel = '0;
  logic [63:0] result;
  logic        illegal;
  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  rv64_shift_unit u_rv64_shift_unit (
    .clk(clk), .rst(rst), .opd_a(opd_a), .rs_src(rs_src), .imm_amt(imm_amt),
    .use_imm(use_imm), .op_sel(op_sel), .word_mode(word_mode),
    .result(result), .illegal(illegal)
  );

  typedef struct packed {
    logic [63:0] a;
    logic [63:0] rs;
    logic [5:0]  imm;
    logic        ui;
    logic [1:0]  op;
    logic        wm;
    logic [3:0]  req;
  } vec_t;

  localparam vec_t TBL [0:11] = '{
    '{64'h0000_0000_0000_0001, 64'd63, 6'd0, 1'b0, 2'd0, 1'b0, 4'd1},
    '{64'hDEAD_BEEF_0123_4567, 64'hFFFF_0000_0000_0104, 6'd0, 1'b0, 2'd0, 1'b0, 4'd4},
    '{64'h8000_0000_0000_0000, 64'd63, 6'd0, 1'b0, 2'd1, 1'b0, 4'd2},
    '{64'h8765_4321_0FED_CBA9, 64'd12, 6'd0, 1'b0, 2'd2, 1'b0, 4'd3},
    '{64'h7765_4321_0FED_CBA9, 64'd12, 6'd0, 1'b0, 2'd2, 1'b0, 4'd3},
    '{64'h1234_5678_9ABC_DEF0, 64'd0, 6'd40, 1'b1, 2'd1, 1'b0, 4'd12},
    '{64'hFFFF_FFFF_4000_0001, 64'd1, 6'd0, 1'b0, 2'd0, 1'b1, 4'd5},
    '{64'h0000_0000_0000_0003, 64'h0000_0000_0000_003E, 6'd0, 1'b0, 2'd0, 1'b1, 4'd6},
    '{64'h0000_0000_F000_0000, 64'd8, 6'd0, 1'b0, 2'd2, 1'b1, 4'd7},
    '{64'hAAAA_AAAA_8000_0000, 64'd0, 6'd0, 1'b0, 2'd1, 1'b1, 4'd8},
    '{64'h0000_0000_0000_00FF, 64'd0, 6'd33, 1'b1, 2'd1, 1'b1, 4'd9},
    '{64'h0000_0000_0000_00FF, 64'd0, 6'd5, 1'b0, 2'd3, 1'b0, 4'd10}
  };

  function automatic logic [64:0] ref_model(logic [63:0] a, logic [63:0] rs,
      logic [5:0] imm, logic ui, logic [1:0] op, logic wm);
    logic [5:0]         s;
    logic               ill;
    logic signed [63:0] sa;
    logic signed [31:0] sw;
    logic [31:0]        w;
    logic [63:0]        r;
    s   = ui ? imm : rs[5:0];
    ill = (op == 2'd3) || (wm && ui && imm[5]);
    r   = '0;
    if (!ill && !wm) begin
      sa = a;
      case (op)
        2'd0: r = a << s;
        2'd1: r = a >> s;
        default: r = sa >>> s;
      endcase
    end else if (!ill) begin
      sw = a[31:0];
      case (op)
        2'd0: w = a[31:0] << s[4:0];
        2'd1: w = a[31:0] >> s[4:0];
        default: w = sw >>> s[4:0];
      endcase
      r = {{32{w[31]}}, w};
    end
    return {ill, r};
  endfunction

  task automatic apply(logic [63:0] a, logic [63:0] rs, logic [5:0] imm,
                       logic ui, logic [1:0] op, logic wm);
    @(negedge clk);
    opd_a = a; rs_src = rs; imm_amt = imm; use_imm = ui; op_sel = op; word_mode = wm;
    @(negedge clk);
  endtask

  task automatic chk(string req, logic [63:0] exp_r, logic exp_i);
    total++;
    if (result !== exp_r || illegal !== exp_i) begin
      bad++;
      $display("FAIL %s: result=%h illegal=%b expected result=%h illegal=%b",
               req, result, illegal, exp_r, exp_i);
    end
  endtask

  task automatic run_ref(string req, logic [63:0] a, logic [63:0] rs, logic [5:0] imm,
                         logic ui, logic [1:0] op, logic wm);
    logic [64:0] e;
    e = ref_model(a, rs, imm, ui, op, wm);
    apply(a, rs, imm, ui, op, wm);
    chk(req, e[63:0], e[64]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: result=%h illegal=%b expected completion", result, illegal);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    opd_a = 64'hFFFF_FFFF_FFFF_FFFF; op_sel = 2'd3;
    repeat (3) @(negedge clk);
    chk("R11 reset", 64'd0, 1'b0);
    rst = 1'b0;

    for (int i = 0; i < 12; i++) begin
      string tag;
      tag = $sformatf("R%0d table %0d", TBL[i].req, i);
      run_ref(tag, TBL[i].a, TBL[i].rs, TBL[i].imm, TBL[i].ui, TBL[i].op, TBL[i].wm);
    end

    // directed corners with hand-computed values
    apply(64'd1, 64'd63, 6'd0, 1'b0, 2'd0, 1'b0);
    chk("R1 sll by 63", 64'h8000_0000_0000_0000, 1'b0);
    apply(64'd5, 64'h40, 6'd0, 1'b0, 2'd0, 1'b0);
    chk("R4 rs bit6 ignored, pass", 64'd5, 1'b0);
    apply(64'h8000_0000_0000_0000, 64'd63, 6'd0, 1'b0, 2'd1, 1'b0);
    chk("R2 srl by 63", 64'd1, 1'b0);
    apply(64'h8000_0000_0000_0000, 64'd63, 6'd0, 1'b0, 2'd2, 1'b0);
    chk("R3 sra by 63", 64'hFFFF_FFFF_FFFF_FFFF, 1'b0);
    apply(64'h10, 64'd60, 6'd4, 1'b1, 2'd0, 1'b0);
    chk("R12 immediate amount", 64'h100, 1'b0);
    apply(64'h0000_0000_8000_0000, 64'd0, 6'd0, 1'b0, 2'd1, 1'b1);
    chk("R8 srlw by 0 negative", 64'hFFFF_FFFF_8000_0000, 1'b0);
    apply(64'h0000_0000_8000_0000, 64'd1, 6'd0, 1'b0, 2'd1, 1'b1);
    chk("R8 srlw by 1 positive", 64'h0000_0000_4000_0000, 1'b0);
    apply(64'h0000_0000_8000_0000, 64'd4, 6'd0, 1'b0, 2'd2, 1'b1);
    chk("R7 sraw sign from bit31", 64'hFFFF_FFFF_F800_0000, 1'b0);
    apply(64'h8000_0000_0000_0001, 64'd0, 6'd0, 1'b0, 2'd2, 1'b1);
    chk("R5 upper half ignored", 64'd1, 1'b0);
    apply(64'h0000_0000_4000_0000, 64'd1, 6'd0, 1'b0, 2'd0, 1'b1);
    chk("R5 sllw sign extends", 64'hFFFF_FFFF_8000_0000, 1'b0);
    apply(64'd1, 64'h21, 6'd0, 1'b0, 2'd0, 1'b1);
    chk("R6 rs bit5 dropped in word", 64'd2, 1'b0);
    apply(64'd1, 64'd0, 6'h21, 1'b1, 2'd0, 1'b1);
    chk("R9 imm word bit5 illegal", 64'd0, 1'b1);
    apply(64'd1, 64'd0, 6'h21, 1'b1, 2'd0, 1'b0);
    chk("R12 imm bit5 legal full", 64'd2 << 32, 1'b0);
    apply(64'hFFFF, 64'd2, 6'd0, 1'b0, 2'd3, 1'b1);
    chk("R10 reserved op", 64'd0, 1'b1);
    // R11: outputs follow the previous edge's inputs
    apply(64'hF0, 64'd4, 6'd0, 1'b0, 2'd1, 1'b0);
    chk("R11 latency", 64'h0F, 1'b0);
    // R11: reset clears a nonzero result
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    chk("R11 reset clears", 64'd0, 1'b0);
    rst = 1'b0;

    for (int k = 0; k < 600; k++) begin
      logic [63:0] a, rs;
      logic [5:0]  imm;
      logic        ui, wm;
      logic [1:0]  op;
      a   = {$urandom, $urandom};
      rs  = {$urandom, $urandom};
      imm = 6'($urandom);
      ui  = 1'($urandom);
      wm  = 1'($urandom);
      op  = 2'($urandom);
      if (wm) run_ref("R5 random word", a, rs, imm, ui, op, wm);
      else    run_ref("R1 random full", a, rs, imm, ui, op, wm);
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule